// File: doc/BRIEF.md
# Branch Unit with Automatic Return Register

The branch unit keeps the program counter of a small processor together with a return-address register that software can read but cannot write. In every clock cycle the decoder gives it the class of the current instruction, the length of that instruction in bytes, a 32-bit jump destination and the live condition flags. The unit works out whether a jump is taken and loads the next program counter.

Any taken jump loads the destination. Conditional jumps are included, and no separate call instruction is needed. A taken jump also saves the address just after the jump into the return register. A jump that is not taken, and every other instruction, advances the counter by the instruction length and leaves the return register alone. All three outputs come from registers. A one-cycle taken pulse appears in the same cycle that the counter shows the destination.

Instruction class codes on `kind_i`: 0 = plain (no-op or any non-jump), 1 = unconditional jump, 2 = jump on zero, 3 = jump on non-zero, 4 = jump on greater, 5 = jump on less, 6 = jump on equal, 7 = reserved, which is handled as plain. Flag bits on `flags_i`: bit 0 = zero, bit 1 = greater, bit 2 = less.

Top module: `branch_unit`

## Requirements
- R1: When `rst` is high at a clock edge, `pc_o`, `ret_o` and `taken_o` are all 0 after that edge.
- R2: With `kind_i` 0 or 7, `pc_o` becomes the old `pc_o` plus `len_i` after the edge, whatever the flags are, and `taken_o` is 0.
- R3: With `kind_i` = 1, the jump is taken for every flag value and `pc_o` becomes `target_i`.
- R4: On a taken jump, `ret_o` becomes the old `pc_o` plus `len_i`, which is the address after the jump.
- R5: With `kind_i` 2 (zero) or 6 (equal), the jump is taken exactly when flag bit 0 is 1.
- R6: With `kind_i` = 3, the jump is taken exactly when flag bit 0 is 0.
- R7: With `kind_i` = 4, the jump is taken exactly when flag bit 1 is 1. With `kind_i` = 5, it is taken exactly when flag bit 2 is 1.
- R8: A jump that is not taken advances `pc_o` by `len_i` and leaves `ret_o` unchanged.
- R9: `taken_o` is high for exactly the one cycle after the edge that took the jump, and `pc_o` equals the destination in that same cycle.
- R10: The additions for the counter and the return address wrap modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| kind_i | input | 3 | Instruction class code |
| len_i | input | 4 | Current instruction length in bytes |
| target_i | input | 32 | Jump destination address |
| flags_i | input | 3 | Condition flags {less, greater, zero} |
| pc_o | output | 32 | Program counter |
| ret_o | output | 32 | Return-address register |
| taken_o | output | 1 | High for the cycle after a taken jump |

## Verification
Every result has a latency of one edge. Inputs presented before a rising edge show up on `pc_o`, `ret_o` and `taken_o` immediately after that edge, and the next instruction can be given straight away. The bench changes inputs on the falling edge, lets one rising edge pass, and then compares all three outputs on the following falling edge. It keeps a running model of the counter and the return register, so each comparison builds on the one before. The directed cases cover the wrap at the top of the address space and a reset applied in the middle of a run.

// File: rtl/bru_pkg.sv
package bru_pkg;
  typedef enum logic [2:0] {
    K_PLAIN = 3'd0,
    K_JMP   = 3'd1,
    K_JZ    = 3'd2,
    K_JNZ   = 3'd3,
    K_JGT   = 3'd4,
    K_JLT   = 3'd5,
    K_JEQ   = 3'd6,
    K_RSVD  = 3'd7
  } kind_e;

  localparam int FLAG_W  = 3;
  localparam int FLAG_Z  = 0;
  localparam int FLAG_GT = 1;
  localparam int FLAG_LT = 2;
endpackage

// File: rtl/bru_cond.sv
module bru_cond
  import bru_pkg::*;
(
  input  logic [2:0]        kind,
  input  logic [FLAG_W-1:0] flags,
  output logic              take
);
  kind_e k;
  assign k = kind_e'(kind);

  always_comb begin
    case (k)
      K_JMP:   take = 1'b1;
      K_JZ,
      K_JEQ:   take = flags[FLAG_Z];
      K_JNZ:   take = ~flags[FLAG_Z];
      K_JGT:   take = flags[FLAG_GT];
      K_JLT:   take = flags[FLAG_LT];
      default: take = 1'b0;
    endcase
  end
endmodule

// File: rtl/bru_nextpc.sv
module bru_nextpc #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 4
) (
  input  logic [ADDR_W-1:0] pc,
  input  logic [LEN_W-1:0]  len,
  input  logic [ADDR_W-1:0] target,
  input  logic              take,
  output logic [ADDR_W-1:0] fall,
  output logic [ADDR_W-1:0] nxt
);
  assign fall = pc + ADDR_W'(len);
  assign nxt  = take ? target : fall;
endmodule

// File: rtl/branch_unit.sv
module branch_unit
  import bru_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        kind_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [ADDR_W-1:0] target_i,
  input  logic [FLAG_W-1:0] flags_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic [ADDR_W-1:0] ret_o,
  output logic              taken_o
);
  logic              take;
  logic [ADDR_W-1:0] fall, nxt;

  bru_cond u_cond (
    .kind  (kind_i),
    .flags (flags_i),
    .take  (take)
  );

  bru_nextpc #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_next (
    .pc     (pc_o),
    .len    (len_i),
    .target (target_i),
    .take   (take),
    .fall   (fall),
    .nxt    (nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_o    <= '0;
      ret_o   <= '0;
      taken_o <= 1'b0;
    end else begin
      pc_o    <= nxt;
      taken_o <= take;
      if (take) ret_o <= fall;
    end
  end

  // R3 R9
  taken_pc_chk: assert property (@(posedge clk) disable iff (rst)
    (taken_o && !$past(rst)) |-> pc_o == $past(target_i));

  // R4
  taken_ret_chk: assert property (@(posedge clk) disable iff (rst)
    (taken_o && !$past(rst)) |-> ret_o == $past(pc_o) + ADDR_W'($past(len_i)));

  // R8
  hold_ret_chk: assert property (@(posedge clk) disable iff (rst)
    (!taken_o && !$past(rst)) |-> ($stable(ret_o) && pc_o == $past(pc_o) + ADDR_W'($past(len_i))));

  // R2
  plain_no_take_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(kind_i) == K_PLAIN || $past(kind_i) == K_RSVD)) |-> !taken_o);

  // R3
  jmp_take_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(kind_i) == K_JMP) |-> taken_o);
endmodule

// File: tb/branch_unit_tb.sv
module branch_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  kind_i = '0;
  logic [3:0]  len_i = '0;
  logic [31:0] target_i = '0;
  logic [2:0]  flags_i = '0;
  logic [31:0] pc_o, ret_o;
  logic        taken_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] m_pc = '0;
  logic [31:0] m_ret = '0;

  always #2 clk = ~clk;

  branch_unit u_dut (
    .clk(clk), .rst(rst), .kind_i(kind_i), .len_i(len_i),
    .target_i(target_i), .flags_i(flags_i),
    .pc_o(pc_o), .ret_o(ret_o), .taken_o(taken_o)
  );

  // vector: kind(3) len(4) target(32) flags{lt,gt,z}(3) expected_taken(1)
  localparam logic [42:0] VEC [15] = '{
    {3'd0, 4'd2, 32'h0000_0000, 3'b000, 1'b0},
    {3'd1, 4'd5, 32'h0000_0100, 3'b000, 1'b1},
    {3'd2, 4'd5, 32'h0000_0200, 3'b000, 1'b0},
    {3'd2, 4'd5, 32'h0000_0200, 3'b001, 1'b1},
    {3'd3, 4'd5, 32'h0000_0300, 3'b001, 1'b0},
    {3'd3, 4'd5, 32'h0000_0300, 3'b000, 1'b1},
    {3'd4, 4'd5, 32'h0000_0400, 3'b010, 1'b1},
    {3'd4, 4'd5, 32'h0000_0400, 3'b100, 1'b0},
    {3'd5, 4'd5, 32'h0000_0500, 3'b100, 1'b1},
    {3'd5, 4'd5, 32'h0000_0500, 3'b011, 1'b0},
    {3'd6, 4'd5, 32'h0000_0600, 3'b001, 1'b1},
    {3'd6, 4'd5, 32'h0000_0600, 3'b000, 1'b0},
    {3'd7, 4'd3, 32'h0000_0700, 3'b111, 1'b0},
    {3'd1, 4'd5, 32'h0000_0800, 3'b111, 1'b1},
    {3'd0, 4'd1, 32'h0000_0900, 3'b001, 1'b0}
  };

  function automatic string tag_of(input logic [2:0] k);
    case (k)
      3'd1:       return "R3";
      3'd2, 3'd6: return "R5";
      3'd3:       return "R6";
      3'd4, 3'd5: return "R7";
      default:    return "R2";
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // drive at negedge, one rising edge, compare at the next negedge
  task automatic step(input logic [2:0] k, input logic [3:0] l,
                      input logic [31:0] t, input logic [2:0] f,
                      input logic tk, input string req);
    kind_i = k; len_i = l; target_i = t; flags_i = f;
    if (tk) begin
      m_ret = m_pc + 32'(l);
      m_pc  = t;
    end else begin
      m_pc  = m_pc + 32'(l);
    end
    @(negedge clk);
    check(req, "taken", {31'd0, taken_o}, {31'd0, tk});
    check(tk ? "R9" : "R8", "pc", pc_o, m_pc);
    check(tk ? "R4" : "R8", "ret", ret_o, m_ret);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "pc", pc_o, 32'd0);
    check("R1", "ret", ret_o, 32'd0);
    check("R1", "taken", {31'd0, taken_o}, 32'd0);
    rst = 1'b0;

    for (int i = 0; i < 15; i++) begin
      logic [42:0] v;
      v = VEC[i];
      step(v[42:40], v[39:36], v[35:4], v[3:1], v[0], tag_of(v[42:40]));
    end

    // R9 pulse is one cycle: plain instruction right after a taken jump
    step(3'd1, 4'd5, 32'h0000_1000, 3'b000, 1'b1, "R9");
    step(3'd0, 4'd4, 32'h0000_2000, 3'b000, 1'b0, "R9");

    // R10 wrap of the counter and of the return address
    step(3'd1, 4'd5, 32'hFFFF_FFFE, 3'b000, 1'b1, "R10");
    step(3'd0, 4'd5, 32'h0000_0000, 3'b000, 1'b0, "R10");
    check("R10", "pc wrap", pc_o, 32'h0000_0003);
    step(3'd1, 4'd5, 32'hFFFF_FFFC, 3'b000, 1'b1, "R10");
    step(3'd1, 4'd5, 32'h0000_0040, 3'b000, 1'b1, "R10");
    check("R10", "ret wrap", ret_o, 32'h0000_0001);

    // R1 reset in mid-run
    rst = 1'b1;
    @(negedge clk);
    check("R1", "pc mid", pc_o, 32'd0);
    check("R1", "ret mid", ret_o, 32'd0);
    check("R1", "taken mid", {31'd0, taken_o}, 32'd0);
    rst = 1'b0;
    m_pc = '0; m_ret = '0;
    step(3'd5, 4'd5, 32'h0000_0ABC, 3'b000, 1'b0, "R7");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule